// File: doc/BRIEF.md
# Read Training FIFO

This block is the device-side store that a graphics DRAM model uses while a memory controller calibrates its read and write data paths. It holds six burst entries. Each entry is one byte lane of eight beats, and each beat carries eight data bits plus a bus-inversion bit. The command decoder upstream presents three one-cycle strobes:

- A pattern load fills one beat of the current entry from bits carried on the address inputs.
- A training write drops a whole eight-beat write burst into the current entry.
- A training read plays the next entry back as a burst on the read outputs.

Fills and drains each follow their own circular pointer. The controller can therefore preload patterns, or loop its own write data back, and then read the entries out in order with reads issued back to back. The beats come out after a fixed latency that is set by a parameter. A valid flag marks every beat.

Top module: `rdtrain_fifo`

## Requirements
- R1: Reset (synchronous, active high) returns both pointers and the load slice to zero and clears every entry, so that later reads return all-zero beats. rd_valid stays low and rd_data reads zero while reset is held.
- R2: The store holds six entries. The fill pointer and the drain pointer each step from 5 back to 0, so a seventh training write overwrites entry 0.
- R3: A training write stores wr_burst whole into the entry at the fill pointer and advances the fill pointer. Beat k sits at bits [9k+8:9k], and bit 9k+8 is that beat's inversion bit.
- R4: A pattern load stores ld_addr[7:0] as data and ld_addr[8] as the inversion bit into the beat selected by the load slice counter, within the entry at the fill pointer. The slice counter advances on every load. The eighth load advances the fill pointer and returns the slice to 0. A training write also returns the slice to 0.
- R5: When a training write and a pattern load arrive in the same cycle, the write is performed and the load has no effect.
- R6: The first beat of an accepted read appears RD_LAT rising edges after the edge that samples the strobe (4 by default). Beats 0 to 7 then follow on consecutive cycles with rd_valid high. Outside a burst, rd_valid is low and rd_data and rd_dbi are zero.
- R7: Reads accepted eight cycles apart produce one unbroken run of beats, with no idle gap between bursts. Each accepted read advances the drain pointer.
- R8: A read strobe that arrives less than eight cycles after an accepted read is ignored. It produces no burst and does not advance the drain pointer.
- R9: A read and a write that address the same entry in the same cycle return that entry's previous contents. The new burst is kept for later reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_stb | input | 1 | Pattern-load strobe |
| ld_addr | input | 9 | Address-bus bits for one beat: [7:0] data, [8] inversion bit |
| wr_stb | input | 1 | Training-write strobe |
| wr_burst | input | 72 | Eight-beat write burst, beat k at [9k+8:9k] |
| rd_stb | input | 1 | Training-read strobe |
| rd_data | output | 8 | Read beat data |
| rd_dbi | output | 1 | Read beat inversion bit |
| rd_valid | output | 1 | High for each beat of a read burst |

## Verification
All state inside the block becomes visible through read bursts. A wrong fill pointer or a wrong slice counter shows up as a beat landing in the wrong entry or the wrong beat position. That error appears in the first burst that drains the affected entry, up to six reads later. A wrong drain pointer or a wrong spacing counter shows up immediately, as a shifted entry order or a missing or extra burst. A latency error shows up as rd_valid rising one cycle early or late on the very first read. The directed scenarios are built so that each of these faults changes a value that the bench samples within one pass through all six entries.

// File: rtl/rdtf_pkg.sv
`timescale 1ns/1ps
package rdtf_pkg;
  // circular increment used by both pointers
  function automatic int unsigned wrap_next(int unsigned cur, int unsigned lim);
    return (cur + 1 >= lim) ? 0 : cur + 1;
  endfunction
endpackage

// File: rtl/rdtf_ctrl.sv
`timescale 1ns/1ps
module rdtf_ctrl
  import rdtf_pkg::*;
#(
  parameter int DEPTH = 6,
  parameter int BEATS = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int SLC_W = $clog2(BEATS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_stb,
  input  logic             wr_stb,
  input  logic             rd_stb,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr,
  output logic [SLC_W-1:0] slice,
  output logic             ld_we,
  output logic             wr_we,
  output logic             rd_acc
);
  logic [SLC_W-1:0] gap;
  logic             slice_last;

  assign wr_we      = wr_stb;
  assign ld_we      = ld_stb & ~wr_stb;   // write wins over load
  assign rd_acc     = rd_stb & (gap == '0);
  assign slice_last = (slice == SLC_W'(BEATS - 1));

  // fill side: pointer and beat slice
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      slice  <= '0;
    end else if (wr_we) begin
      wr_ptr <= PTR_W'(wrap_next(32'(wr_ptr), DEPTH));
      slice  <= '0;
    end else if (ld_we) begin
      if (slice_last) begin
        slice  <= '0;
        wr_ptr <= PTR_W'(wrap_next(32'(wr_ptr), DEPTH));
      end else begin
        slice <= slice + 1'b1;
      end
    end
  end

  // drain side: pointer and spacing counter
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr <= '0;
      gap    <= '0;
    end else if (rd_acc) begin
      rd_ptr <= PTR_W'(wrap_next(32'(rd_ptr), DEPTH));
      gap    <= SLC_W'(BEATS - 1);
    end else if (gap != '0) begin
      gap <= gap - 1'b1;
    end
  end

  a_r2_ptr_range: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, wr_ptr} < (PTR_W+1)'(DEPTH)) && ({1'b0, rd_ptr} < (PTR_W+1)'(DEPTH)));
  a_r2_fill_wrap: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && wr_ptr == PTR_W'(DEPTH - 1)) |=> (wr_ptr == '0));
  a_r4_slice_clear: assert property (@(posedge clk) disable iff (rst)
    wr_stb |=> (slice == '0));
  a_r8_spacing: assert property (@(posedge clk) disable iff (rst)
    rd_acc |=> !rd_acc);
endmodule

// File: rtl/rdtf_store.sv
`timescale 1ns/1ps
module rdtf_store #(
  parameter int DEPTH  = 6,
  parameter int BEATS  = 8,
  parameter int BEAT_W = 9,
  localparam int PTR_W   = $clog2(DEPTH),
  localparam int SLC_W   = $clog2(BEATS),
  localparam int BURST_W = BEATS * BEAT_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_we,
  input  logic [BURST_W-1:0] wr_burst,
  input  logic               ld_we,
  input  logic [BEAT_W-1:0]  ld_beat,
  input  logic [SLC_W-1:0]   slice,
  input  logic [PTR_W-1:0]   wr_ptr,
  input  logic               rd_en,
  input  logic [PTR_W-1:0]   rd_ptr,
  output logic [BURST_W-1:0] rd_entry,
  output logic               rd_entry_vld
);
  logic [BEATS-1:0] we_vec;

  // one narrow bank per beat position, written whole or one beat at a time
  for (genvar b = 0; b < BEATS; b++) begin : g_bank
    logic [BEAT_W-1:0] mem [DEPTH];
    logic [BEAT_W-1:0] din;
    logic [BEAT_W-1:0] rd_q;

    assign we_vec[b] = wr_we | (ld_we & (slice == SLC_W'(b)));
    assign din       = wr_we ? wr_burst[b*BEAT_W +: BEAT_W] : ld_beat;

    always_ff @(posedge clk) begin
      if (rst) begin
        for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (we_vec[b]) begin
        mem[wr_ptr] <= din;
      end
    end

    // registered read, old data on a same-entry collision
    always_ff @(posedge clk) begin
      if (rd_en) rd_q <= mem[rd_ptr];
    end

    assign rd_entry[b*BEAT_W +: BEAT_W] = rd_q;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_entry_vld <= 1'b0;
    else     rd_entry_vld <= rd_en;
  end

  a_r5_bank_we: assert property (@(posedge clk) disable iff (rst)
    $onehot0(we_vec) || (&we_vec));
endmodule

// File: rtl/rdtf_rdpath.sv
`timescale 1ns/1ps
module rdtf_rdpath #(
  parameter int BEATS  = 8,
  parameter int BEAT_W = 9,
  parameter int RD_LAT = 4,
  localparam int BURST_W = BEATS * BEAT_W,
  localparam int CNT_W   = $clog2(BEATS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_vld,
  input  logic [BURST_W-1:0] in_burst,
  output logic [BEAT_W-1:0]  out_beat,
  output logic               out_vld
);
  logic               tail_vld;
  logic [BURST_W-1:0] tail_burst;
  logic [BURST_W-1:0] shreg;
  logic [CNT_W-1:0]   cnt;

  // extra delay stages, the storage read register being the first one
  if (RD_LAT > 1) begin : g_dly
    localparam int NS = RD_LAT - 1;
    logic [NS-1:0]      sv;
    logic [BURST_W-1:0] sd [NS];

    always_ff @(posedge clk) begin
      if (rst) begin
        sv <= '0;
      end else begin
        sv[0] <= in_vld;
        for (int i = 1; i < NS; i++) sv[i] <= sv[i-1];
      end
    end

    always_ff @(posedge clk) begin
      sd[0] <= in_burst;
      for (int i = 1; i < NS; i++) sd[i] <= sd[i-1];
    end

    assign tail_vld   = sv[NS-1];
    assign tail_burst = sd[NS-1];
  end else begin : g_nodly
    assign tail_vld   = in_vld;
    assign tail_burst = in_burst;
  end

  // burst serializer with registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      out_beat <= '0;
      out_vld  <= 1'b0;
      shreg    <= '0;
      cnt      <= '0;
    end else if (tail_vld) begin
      out_beat <= tail_burst[BEAT_W-1:0];
      out_vld  <= 1'b1;
      shreg    <= tail_burst >> BEAT_W;
      cnt      <= CNT_W'(BEATS - 1);
    end else if (cnt != '0) begin
      out_beat <= shreg[BEAT_W-1:0];
      out_vld  <= 1'b1;
      shreg    <= shreg >> BEAT_W;
      cnt      <= cnt - 1'b1;
    end else begin
      out_beat <= '0;
      out_vld  <= 1'b0;
    end
  end

  a_r6_head_follows: assert property (@(posedge clk) disable iff (rst)
    tail_vld |=> out_vld);
  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !out_vld |-> (out_beat == '0));
  a_r7_stream_end: assert property (@(posedge clk) disable iff (rst)
    (!tail_vld && cnt == '0) |=> !out_vld);
endmodule

// File: rtl/rdtrain_fifo.sv
`timescale 1ns/1ps
module rdtrain_fifo #(
  parameter int DEPTH  = 6,
  parameter int BEATS  = 8,
  parameter int LANE_W = 8,
  parameter int RD_LAT = 4,
  localparam int BEAT_W  = LANE_W + 1,
  localparam int BURST_W = BEATS * BEAT_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ld_stb,
  input  logic [BEAT_W-1:0]  ld_addr,
  input  logic               wr_stb,
  input  logic [BURST_W-1:0] wr_burst,
  input  logic               rd_stb,
  output logic [LANE_W-1:0]  rd_data,
  output logic               rd_dbi,
  output logic               rd_valid
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int SLC_W = $clog2(BEATS);

  logic [PTR_W-1:0]   wr_ptr, rd_ptr;
  logic [SLC_W-1:0]   slice;
  logic               ld_we, wr_we, rd_acc;
  logic [BURST_W-1:0] entry;
  logic               entry_vld;
  logic [BEAT_W-1:0]  beat;

  rdtf_ctrl #(.DEPTH(DEPTH), .BEATS(BEATS)) u_ctrl (
    .clk(clk), .rst(rst), .ld_stb(ld_stb), .wr_stb(wr_stb), .rd_stb(rd_stb),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .slice(slice),
    .ld_we(ld_we), .wr_we(wr_we), .rd_acc(rd_acc)
  );

  rdtf_store #(.DEPTH(DEPTH), .BEATS(BEATS), .BEAT_W(BEAT_W)) u_store (
    .clk(clk), .rst(rst), .wr_we(wr_we), .wr_burst(wr_burst),
    .ld_we(ld_we), .ld_beat(ld_addr), .slice(slice), .wr_ptr(wr_ptr),
    .rd_en(rd_acc), .rd_ptr(rd_ptr), .rd_entry(entry), .rd_entry_vld(entry_vld)
  );

  rdtf_rdpath #(.BEATS(BEATS), .BEAT_W(BEAT_W), .RD_LAT(RD_LAT)) u_rdpath (
    .clk(clk), .rst(rst), .in_vld(entry_vld), .in_burst(entry),
    .out_beat(beat), .out_vld(rd_valid)
  );

  assign rd_data = beat[LANE_W-1:0];
  assign rd_dbi  = beat[LANE_W];

  a_r1_reset_idle: assert property (@(posedge clk)
    $past(rst) |-> !rd_valid);
endmodule

// File: tb/test_rdtrain_fifo.sv
`timescale 1ns/1ps
module test_rdtrain_fifo;
  localparam int DEPTH = 6, BEATS = 8, LANE_W = 8, RD_LAT = 4;
  localparam int BEAT_W = LANE_W + 1, BURST_W = BEATS * BEAT_W;

  logic clk = 1'b0;
  logic rst, ld_stb, wr_stb, rd_stb;
  logic [BEAT_W-1:0]  ld_addr;
  logic [BURST_W-1:0] wr_burst;
  logic [LANE_W-1:0]  rd_data;
  logic rd_dbi, rd_valid;

  always #2 clk = ~clk;

  rdtrain_fifo #(.DEPTH(DEPTH), .BEATS(BEATS), .LANE_W(LANE_W), .RD_LAT(RD_LAT)) i_rdtrain_fifo (
    .clk(clk), .rst(rst), .ld_stb(ld_stb), .ld_addr(ld_addr), .wr_stb(wr_stb),
    .wr_burst(wr_burst), .rd_stb(rd_stb), .rd_data(rd_data), .rd_dbi(rd_dbi), .rd_valid(rd_valid)
  );

  int checks = 0, fails = 0;
  logic [BURST_W-1:0] m_mem [DEPTH];
  int m_wp, m_rp, m_sl;
  logic              exp_v [512];
  logic [BEAT_W-1:0] exp_b [512];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [BURST_W-1:0] act, input logic [BURST_W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [BURST_W-1:0] mk_burst(input int seed);
    logic [BURST_W-1:0] b;
    for (int k = 0; k < BEATS; k++)
      b[k*BEAT_W +: BEAT_W] = {1'(seed + k), 8'(seed * 37 + k * 11 + 5)};
    return b;
  endfunction

  task automatic do_reset();
    rst = 1'b1; ld_stb = 0; wr_stb = 0; rd_stb = 0; ld_addr = '0; wr_burst = '0;
    repeat (3) @(negedge clk);
    chk(!rd_valid && rd_data == '0 && !rd_dbi, "R1", "outputs during reset",
        {rd_valid, rd_dbi, rd_data}, '0);
    rst = 1'b0;
    for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
    m_wp = 0; m_rp = 0; m_sl = 0;
  endtask

  task automatic twrite(input logic [BURST_W-1:0] b);
    wr_stb = 1; wr_burst = b;
    @(negedge clk);
    wr_stb = 0;
    m_mem[m_wp] = b; m_wp = (m_wp + 1) % DEPTH; m_sl = 0;
  endtask

  task automatic tload(input logic [BEAT_W-1:0] v);
    ld_stb = 1; ld_addr = v;
    @(negedge clk);
    ld_stb = 0;
    m_mem[m_wp][m_sl*BEAT_W +: BEAT_W] = v;
    if (m_sl == BEATS - 1) begin m_sl = 0; m_wp = (m_wp + 1) % DEPTH; end
    else m_sl++;
  endtask

  // issues n read strobes 'spacing' cycles apart and checks every output cycle
  task automatic run_reads(input int n, input int spacing, input string req);
    int total, last;
    total = n * spacing + RD_LAT + BEATS + 4;
    last = -1000;
    for (int c = 0; c < total; c++) begin exp_v[c] = 0; exp_b[c] = '0; end
    for (int r = 0; r < n; r++) begin
      int s;
      s = r * spacing;
      if (s >= last + BEATS) begin
        for (int k = 0; k < BEATS; k++) begin
          exp_v[s + RD_LAT + k + 1] = 1;
          exp_b[s + RD_LAT + k + 1] = m_mem[m_rp][k*BEAT_W +: BEAT_W];
        end
        m_rp = (m_rp + 1) % DEPTH;
        last = s;
      end
    end
    for (int c = 0; c < total; c++) begin
      chk(rd_valid == exp_v[c] && {rd_dbi, rd_data} == exp_b[c], req, $sformatf("cycle %0d beat", c),
          {rd_valid, rd_dbi, rd_data}, {exp_v[c], exp_b[c]});
      rd_stb = (c % spacing == 0) && (c / spacing < n);
      @(negedge clk);
    end
    rd_stb = 0;
  endtask

  task automatic t_reset();
    do_reset();
    twrite(mk_burst(3)); twrite(mk_burst(9));
    do_reset();
    run_reads(2, 8, "R1");  // cleared entries read back as zeros
  endtask

  task automatic t_write_read();
    do_reset();
    for (int i = 0; i < 3; i++) twrite(mk_burst(20 + i));
    run_reads(3, 8, "R3");  // also R6 latency and R7 unbroken run
  endtask

  task automatic t_wrap();
    do_reset();
    for (int i = 0; i < 7; i++) twrite(mk_burst(40 + i));
    run_reads(7, 8, "R2");  // seventh read wraps back to entry 0 (R7)
  endtask

  task automatic t_load();
    do_reset();
    for (int i = 0; i < 8; i++) tload(9'(60 + i * 29));
    for (int i = 0; i < 3; i++) tload(9'(300 + i));
    twrite(mk_burst(77));   // slice back to 0
    tload(9'h1A5); tload(9'h05A);
    run_reads(3, 8, "R4");
  endtask

  task automatic t_collide();
    do_reset();
    ld_stb = 1; ld_addr = 9'h1FF; wr_stb = 1; wr_burst = mk_burst(90);
    @(negedge clk);
    ld_stb = 0; wr_stb = 0;
    m_mem[0] = mk_burst(90); m_wp = 1;
    tload(9'h123);          // lands in beat 0 of entry 1 if slice untouched
    run_reads(2, 8, "R5");
  endtask

  task automatic t_spacing();
    do_reset();
    for (int i = 0; i < 3; i++) twrite(mk_burst(110 + i));
    run_reads(4, 5, "R8");  // strobes at 0,5,10,15: only 0 and 10 accepted
    run_reads(1, 8, "R8");  // entry 2 shows the pointer skipped nothing
  endtask

  task automatic t_same_entry();
    logic [BURST_W-1:0] old;
    do_reset();
    for (int i = 0; i < 6; i++) twrite(mk_burst(130 + i));
    old = m_mem[0];
    rd_stb = 1; wr_stb = 1; wr_burst = mk_burst(200);
    @(negedge clk);
    rd_stb = 0; wr_stb = 0;
    m_rp = 1; m_mem[0] = mk_burst(200); m_wp = 1;
    repeat (RD_LAT - 1) @(negedge clk);
    chk(!rd_valid, "R6", "valid before latency", {rd_valid}, '0);
    @(negedge clk);
    for (int k = 0; k < BEATS; k++) begin
      chk(rd_valid && {rd_dbi, rd_data} == old[k*BEAT_W +: BEAT_W], "R9", $sformatf("old beat %0d", k),
          {rd_valid, rd_dbi, rd_data}, {1'b1, old[k*BEAT_W +: BEAT_W]});
      @(negedge clk);
    end
    chk(!rd_valid, "R6", "valid after burst", {rd_valid}, '0);
    repeat (8) @(negedge clk);
    run_reads(6, 8, "R9");  // new burst appears when entry 0 is drained again
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst = 1; ld_stb = 0; wr_stb = 0; rd_stb = 0; ld_addr = '0; wr_burst = '0;
    @(negedge clk);
    t_reset();
    t_write_read();
    t_wrap();
    t_load();
    t_collide();
    t_spacing();
    t_same_entry();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule